// File: doc/BRIEF.md
# Scalar Double-Precision Flag-Setting Comparator

This block orders two binary64 floating-point operands and turns the outcome into a three-bit condition code held in zero, parity and carry style flags. It also returns three further status bits, which every compare clears. A caller pulses a start strobe with both operands, a mode bit and two exception mask bits. One clock later the block presents the flags, an invalid-operation indication, a denormal-operand indication and a flag write-enable.

The mode bit chooses between two compare flavours. The quiet flavour treats only signalling NaNs as invalid. The signalling flavour treats every NaN as invalid. When a raised exception is not masked, the block still reports the exception, but it keeps the previously held condition flags and deasserts the write-enable. A stalled pipeline can therefore leave its architectural flags untouched while the fault is handled.

Top module: `fp_order_flagger`

## Requirements
- R1: When operand A is ordered above operand B, the flags (zf, pf, cf) become 0,0,0.
- R2: When operand A is ordered below operand B, the flags become 0,0,1.
- R3: Equal operands give the flags 1,0,0. This includes +0 against -0 and two infinities of the same sign.
- R4: A NaN in either operand gives the flags 1,1,1. A NaN has an all-ones exponent (bits 62:52) and a nonzero fraction (bits 51:0).
- R5: The of, sf and af outputs are 0 after every compare.
- R6: With sig_mode_i = 0 (quiet), inv_o is raised only when an operand is a signalling NaN. A NaN is signalling when fraction bit 51 is 0.
- R7: With sig_mode_i = 1 (signalling), inv_o is raised when either operand is any NaN.
- R8: den_o is raised when either operand has a zero exponent and a nonzero fraction.
- R9: A mask bit of 1 masks its exception. If a raised exception is unmasked, flag_we_o is 0 and zf, pf, cf keep their earlier values, while inv_o and den_o still report the exception. Otherwise flag_we_o is 1 and the flags take the new result.
- R10: The outputs change on the first rising clock edge after a start strobe and hold their values until the next strobe.
- R11: Reset (rst_n low) clears every output to 0.
- R12: When both operands are negative, the one with the larger magnitude is ordered below the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Compare strobe, one cycle |
| opa_i | input | 64 | Operand A, binary64 |
| opb_i | input | 64 | Operand B, binary64 |
| sig_mode_i | input | 1 | 0 selects the quiet compare, 1 selects the signalling compare |
| inv_mask_i | input | 1 | 1 masks the invalid exception |
| den_mask_i | input | 1 | 1 masks the denormal exception |
| zf_o | output | 1 | Zero-style flag |
| pf_o | output | 1 | Parity-style flag (unordered) |
| cf_o | output | 1 | Carry-style flag (below) |
| of_o | output | 1 | Overflow-style flag, always cleared |
| sf_o | output | 1 | Sign-style flag, always cleared |
| af_o | output | 1 | Auxiliary-style flag, always cleared |
| inv_o | output | 1 | Invalid-operation exception raised |
| den_o | output | 1 | Denormal-operand exception raised |
| flag_we_o | output | 1 | The flags were written by the last compare |

## Verification
Every result is due exactly one rising edge after the strobe. The bench drives the strobe on a falling edge, releases it on the next falling edge and samples all outputs right there, half a cycle after the capturing edge. It then lets one more idle cycle pass and samples again, which checks that the held values did not move. Flags that an unmasked exception suppressed are compared against the value the bench last saw written, not against the new result.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [1:0] {
    ORD_GT = 2'd0,
    ORD_LT = 2'd1,
    ORD_EQ = 2'd2,
    ORD_UN = 2'd3
  } ord_e;

  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_den;
    logic is_nan;
    logic is_snan;
  } opclass_t;

  typedef struct packed {
    logic zf;
    logic pf;
    logic cf;
    logic ovf;
    logic sgn;
    logic aux;
  } stat_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0]   op_i,
  output opclass_t                cls_o,
  output logic [EXP_W+FRAC_W-1:0] mag_o
);

  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int QBIT = FRAC_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              exp_zero;
  logic              frac_nz;

  always_comb begin
    exp_f    = op_i[W-2 -: EXP_W];
    frac_f   = op_i[FRAC_W-1:0];
    exp_ones = &exp_f;
    exp_zero = ~|exp_f;
    frac_nz  = |frac_f;

    cls_o.sign    = op_i[W-1];
    cls_o.is_nan  = exp_ones & frac_nz;
    cls_o.is_snan = exp_ones & frac_nz & ~frac_f[QBIT];
    cls_o.is_den  = exp_zero & frac_nz;
    cls_o.is_zero = exp_zero & ~frac_nz;
    mag_o         = op_i[W-2:0];
  end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  opclass_t         cls_a_i,
  input  opclass_t         cls_b_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic [MAG_W-1:0] mag_b_i,
  output ord_e             ord_o
);

  logic mag_eq;
  logic mag_gt;
  logic a_above;

  always_comb begin
    mag_eq  = (mag_a_i == mag_b_i);
    mag_gt  = (mag_a_i > mag_b_i);
    // both negative: larger magnitude sits lower
    a_above = cls_a_i.sign ? ~mag_gt : mag_gt;

    if (cls_a_i.is_nan || cls_b_i.is_nan) begin
      ord_o = ORD_UN;
    end else if (cls_a_i.is_zero && cls_b_i.is_zero) begin
      ord_o = ORD_EQ;
    end else if (mag_eq && (cls_a_i.sign == cls_b_i.sign)) begin
      ord_o = ORD_EQ;
    end else if (cls_a_i.sign != cls_b_i.sign) begin
      ord_o = cls_a_i.sign ? ORD_LT : ORD_GT;
    end else begin
      ord_o = a_above ? ORD_GT : ORD_LT;
    end
  end

endmodule

// File: rtl/fpcmp_excpt.sv
module fpcmp_excpt
  import fpcmp_pkg::*;
(
  input  opclass_t cls_a_i,
  input  opclass_t cls_b_i,
  input  ord_e     ord_i,
  input  logic     sig_mode_i,
  input  logic     inv_mask_i,
  input  logic     den_mask_i,
  output stat_t    stat_o,
  output logic     inv_o,
  output logic     den_o,
  output logic     we_o
);

  logic any_nan;
  logic any_snan;
  logic unmasked;

  always_comb begin
    any_nan  = cls_a_i.is_nan | cls_b_i.is_nan;
    any_snan = cls_a_i.is_snan | cls_b_i.is_snan;
    inv_o    = sig_mode_i ? any_nan : any_snan;
    den_o    = cls_a_i.is_den | cls_b_i.is_den;
    unmasked = (inv_o & ~inv_mask_i) | (den_o & ~den_mask_i);
    we_o     = ~unmasked;

    stat_o = '0;
    unique case (ord_i)
      ORD_GT: {stat_o.zf, stat_o.pf, stat_o.cf} = 3'b000;
      ORD_LT: {stat_o.zf, stat_o.pf, stat_o.cf} = 3'b001;
      ORD_EQ: {stat_o.zf, stat_o.pf, stat_o.cf} = 3'b100;
      default: {stat_o.zf, stat_o.pf, stat_o.cf} = 3'b111;
    endcase
  end

endmodule

// File: rtl/fp_order_flagger.sv
module fp_order_flagger
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [EXP_W+FRAC_W:0]   opa_i,
  input  logic [EXP_W+FRAC_W:0]   opb_i,
  input  logic                    sig_mode_i,
  input  logic                    inv_mask_i,
  input  logic                    den_mask_i,
  output logic                    zf_o,
  output logic                    pf_o,
  output logic                    cf_o,
  output logic                    of_o,
  output logic                    sf_o,
  output logic                    af_o,
  output logic                    inv_o,
  output logic                    den_o,
  output logic                    flag_we_o
);

  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int MAG_W = W - 1;
  localparam int N_OPS = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // operand classification, one lane per operand
  logic [W-1:0]     op_arr  [N_OPS];
  opclass_t         cls_arr [N_OPS];
  logic [MAG_W-1:0] mag_arr [N_OPS];

  assign op_arr[0] = opa_i;
  assign op_arr[1] = opb_i;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    fpcmp_classify #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W)
    ) u_cls (
      .op_i (op_arr[gi]),
      .cls_o(cls_arr[gi]),
      .mag_o(mag_arr[gi])
    );
  end

  ord_e ord_w;

  fpcmp_order #(
    .MAG_W(MAG_W)
  ) u_order (
    .cls_a_i(cls_arr[0]),
    .cls_b_i(cls_arr[1]),
    .mag_a_i(mag_arr[0]),
    .mag_b_i(mag_arr[1]),
    .ord_o  (ord_w)
  );

  stat_t stat_d;
  logic  inv_d;
  logic  den_d;
  logic  we_d;

  fpcmp_excpt u_excpt (
    .cls_a_i   (cls_arr[0]),
    .cls_b_i   (cls_arr[1]),
    .ord_i     (ord_w),
    .sig_mode_i(sig_mode_i),
    .inv_mask_i(inv_mask_i),
    .den_mask_i(den_mask_i),
    .stat_o    (stat_d),
    .inv_o     (inv_d),
    .den_o     (den_d),
    .we_o      (we_d)
  );

  // clock enables
  logic  stat_en;
  logic  exc_en;
  stat_t stat_q;
  logic  inv_q;
  logic  den_q;
  logic  we_q;

  always_comb begin
    exc_en  = start_i;
    stat_en = start_i & we_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      stat_q <= '0;
      inv_q  <= 1'b0;
      den_q  <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (exc_en) begin
        inv_q <= inv_d;
        den_q <= den_d;
        we_q  <= we_d;
      end
    end
  end

  assign zf_o      = stat_q.zf;
  assign pf_o      = stat_q.pf;
  assign cf_o      = stat_q.cf;
  assign of_o      = stat_q.ovf;
  assign sf_o      = stat_q.sgn;
  assign af_o      = stat_q.aux;
  assign inv_o     = inv_q;
  assign den_o     = den_q;
  assign flag_we_o = we_q;

endmodule

// File: rtl/fp_order_flagger_chk.sv
module fp_order_flagger_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic [EXP_W+FRAC_W:0] opa_i,
  input logic [EXP_W+FRAC_W:0] opb_i,
  input logic                  sig_mode_i,
  input logic                  zf_o,
  input logic                  pf_o,
  input logic                  cf_o,
  input logic                  inv_o,
  input logic                  den_o,
  input logic                  flag_we_o
);

  localparam int W = 1 + EXP_W + FRAC_W;

  logic a_nan, b_nan, a_snan, b_snan;

  always_comb begin
    a_nan  = (&opa_i[W-2 -: EXP_W]) && (|opa_i[FRAC_W-1:0]);
    b_nan  = (&opb_i[W-2 -: EXP_W]) && (|opb_i[FRAC_W-1:0]);
    a_snan = a_nan && !opa_i[FRAC_W-1];
    b_snan = b_nan && !opb_i[FRAC_W-1];
  end

  // R4: a written unordered result carries all three flags
  p_unordered_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (a_nan || b_nan) |=> (!flag_we_o || (zf_o && pf_o && cf_o)));

  // R7: the signalling flavour flags any NaN as invalid
  p_sig_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && sig_mode_i && (a_nan || b_nan) |=> inv_o);

  // R6: the quiet flavour stays silent without a signalling NaN
  p_quiet_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !sig_mode_i && !(a_snan || b_snan) |=> !inv_o);

  // R10: no strobe, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable({zf_o, pf_o, cf_o, inv_o, den_o, flag_we_o}));

  // R9: a suppressed write leaves the flags alone
  p_suppress_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_i) && !flag_we_o |-> $stable({zf_o, pf_o, cf_o}));

endmodule

bind fp_order_flagger fp_order_flagger_chk #(
  .EXP_W (EXP_W),
  .FRAC_W(FRAC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .sig_mode_i(sig_mode_i),
  .zf_o      (zf_o),
  .pf_o      (pf_o),
  .cf_o      (cf_o),
  .inv_o     (inv_o),
  .den_o     (den_o),
  .flag_we_o (flag_we_o)
);

// File: tb/fp_order_flagger_tb.sv
module fp_order_flagger_tb;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [63:0] opa_i;
  logic [63:0] opb_i;
  logic        sig_mode_i;
  logic        inv_mask_i;
  logic        den_mask_i;
  logic        zf_o, pf_o, cf_o, of_o, sf_o, af_o;
  logic        inv_o, den_o, flag_we_o;

  int n_chk;
  int n_err;
  bit done;

  fp_order_flagger u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .sig_mode_i(sig_mode_i),
    .inv_mask_i(inv_mask_i),
    .den_mask_i(den_mask_i),
    .zf_o      (zf_o),
    .pf_o      (pf_o),
    .cf_o      (cf_o),
    .of_o      (of_o),
    .sf_o      (sf_o),
    .af_o      (af_o),
    .inv_o     (inv_o),
    .den_o     (den_o),
    .flag_we_o (flag_we_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] sample_val(input int idx);
    case (idx)
      0:  return 64'h0000000000000000;
      1:  return 64'h8000000000000000;
      2:  return 64'h0000000000000001;
      3:  return 64'h800FFFFFFFFFFFFF;
      4:  return 64'h3FF0000000000000;
      5:  return 64'hBFF0000000000000;
      6:  return 64'h4000000000000000;
      7:  return 64'hC000000000000000;
      8:  return 64'h7FEFFFFFFFFFFFFF;
      9:  return 64'hFFEFFFFFFFFFFFFF;
      10: return 64'h7FF0000000000000;
      11: return 64'hFFF0000000000000;
      12: return 64'h7FF8000000000000;
      13: return 64'hFFF0000000000001;
      14: return 64'h3FF0000000000001;
      default: return 64'h000FFFFFFFFFFFFF;
    endcase
  endfunction

  function automatic bit is_nan(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
  endfunction

  function automatic bit is_den(input logic [63:0] v);
    return (v[62:52] == 11'h000) && (v[51:0] != 52'd0);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [2:0] held_cc;
    n_chk = 0;
    n_err = 0;
    done = 1'b0;
    rst_n = 1'b0;
    start_i = 1'b0;
    opa_i = '0;
    opb_i = '0;
    sig_mode_i = 1'b0;
    inv_mask_i = 1'b1;
    den_mask_i = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset", {55'd0, zf_o, pf_o, cf_o, of_o, sf_o, af_o, inv_o, den_o, flag_we_o}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    held_cc = 3'b000;
    for (int md = 0; md < 2; md++) begin
      for (int mk = 0; mk < 4; mk++) begin
        for (int i = 0; i < 16; i++) begin
          for (int j = 0; j < 16; j++) begin
            logic [63:0] a, b;
            logic [2:0]  cc;
            bit          nan_any, snan_any, inv_e, den_e, we_e;
            string       rq;
            real         ra, rb;
            a = sample_val(i);
            b = sample_val(j);
            nan_any  = is_nan(a) || is_nan(b);
            snan_any = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
            if (nan_any) begin
              cc = 3'b111; rq = "R4";
            end else begin
              ra = $bitstoreal(a);
              rb = $bitstoreal(b);
              if (ra > rb)      begin cc = 3'b000; rq = "R1"; end
              else if (ra < rb) begin cc = 3'b001; rq = "R2"; end
              else              begin cc = 3'b100; rq = "R3"; end
              if (a[63] && b[63] && cc != 3'b100) rq = "R12";
            end
            inv_e = (md == 1) ? nan_any : snan_any;
            den_e = is_den(a) || is_den(b);
            we_e  = !((inv_e && !mk[0]) || (den_e && !mk[1]));
            if (we_e) held_cc = cc;
            else rq = "R9";

            opa_i = a;
            opb_i = b;
            sig_mode_i = md[0];
            inv_mask_i = mk[0];
            den_mask_i = mk[1];
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(rq, {61'd0, zf_o, pf_o, cf_o}, {61'd0, held_cc});
            chk("R5", {61'd0, of_o, sf_o, af_o}, 64'd0);
            chk(md == 1 ? "R7" : "R6", {63'd0, inv_o}, {63'd0, inv_e});
            chk("R8", {63'd0, den_o}, {63'd0, den_e});
            chk("R9 we", {63'd0, flag_we_o}, {63'd0, we_e});
            opa_i = ~a;
            opb_i = ~b;
            @(negedge clk);
            // R10: values hold while no strobe arrives
            chk("R10", {58'd0, zf_o, pf_o, cf_o, inv_o, den_o, flag_we_o},
                {58'd0, held_cc, inv_e, den_e, we_e});
          end
        end
      end
    end

    // R11: reset in mid run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 mid", {55'd0, zf_o, pf_o, cf_o, of_o, sf_o, af_o, inv_o, den_o, flag_we_o}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule